// File: doc/BRIEF.md
# Asynchronous Serial Transmit/Receive Unit

This unit moves characters between a parallel register interface and a pair of serial lines. Software configures it through two control registers, polls or takes an interrupt from a status register, and exchanges characters through one data address. Writes to that address feed the transmitter and reads from it return the receiver's data. An external rate generator supplies a single-cycle `bit_tick` pulse once per bit period. The transmitter changes its line on that tick, and the receiver samples its synchronised line on the same tick.

A character is 8 or 9 data bits long. Each character has one low start bit and one high stop bit, and the data bits go out least significant bit first. The transmitter has a holding register in front of a shift register. The receiver sets a full flag and an overrun flag, and sets a framing flag when the stop bit arrives low. Receive flags are cleared by a two-step sequence: a status read, then a data read. A level interrupt request combines the enabled status conditions. A strap input selects a preset that leaves both the transmitter and the receiver enabled after reset.

Top module: `sci_unit`

Register addresses (`reg_addr`): 0 = control A, 1 = control B, 2 = status, 3 = data.

Control A bits: [7] received ninth bit (read-only), [6] ninth bit to send, [4] nine-bit mode, [3] wake method (stored only).

Control B bits: [7] TX-empty interrupt enable, [6] TX-complete interrupt enable, [5] RX interrupt enable, [4] transmit enable, [3] idle interrupt enable, [2] send break, [1] receive enable, [0] wake (stored only).

Status bits: [7] TDRE (transmit holding register empty), [6] TC (transmit complete), [5] RDRF (receive data register full), [4] IDLE (always 0), [3] OR (overrun), [2] NF (always 0), [1] FE (framing error), [0] 0.

## Requirements
- R1: After reset with `boot_mode` low, control A and control B read 0x00, status reads 0xC0, and `irq` is low.
- R2: After reset with `boot_mode` high, control B reads 0x12, which sets transmit enable (bit 4) and receive enable (bit 1).
- R3: With transmit enable set, a held character goes out on `txd` as: one low start bit, the data bits LSB first, control A bit 6 as a ninth bit when nine-bit mode is set, and one high stop bit, each lasting one tick period. `txd` idles high.
- R4: A data write clears TDRE and leaves TC unchanged. Moving the held character into the shifter clears TC. The end of the frame sets both TDRE and TC.
- R5: A data write while TDRE is 0 is ignored and does not change the character that is sent.
- R6: With receive enable set, a received frame sets RDRF. The data address then returns the 8 data bits, and in nine-bit mode control A bit 7 returns the ninth bit.
- R7: While receive enable is clear, the receive line is not sampled and RDRF stays 0.
- R8: A frame that completes while RDRF is set also sets OR, and the data address returns the newer character.
- R9: A status read captures which of RDRF, OR and FE are set, and the next data read clears exactly those flags. A data read with no status read before it clears nothing.
- R10: A frame that completes after a status read cancels that capture, so the next data read leaves RDRF set.
- R11: A frame whose stop bit is sampled low sets FE (status bit 1).
- R12: Writes to the status address have no effect.
- R13: `irq` is high exactly when (bit 7 of control B and TDRE), or (bit 6 and TC), or (bit 5 and (RDRF or OR)) holds. The idle term is always 0.
- R14: While the send-break bit (control B bit 2) is set, `txd` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 1 | Selects the enabled preset for control B during reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the status and data side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request level |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
A wrong bit count or a wrong shift order in the transmitter shows up on `txd` within the frame. It appears either as a misplaced data bit or as a missing stop bit one tick period later. A stale flag or a stale capture register in the receive path shows up only at the next status read: RDRF or OR stays set after the two-step clear, or clears without it. So the bench reads status both before and after every data read. An error in the TDRE or TC sequencing changes the status read, and the `irq` level with it, in the cycle after the write, the load or the frame end.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int CHAR_W  = 8;
  localparam int FRAME_W = CHAR_W + 3;
  localparam int REG_W   = 8;

  localparam logic [1:0] ADR_CTLA = 2'd0;
  localparam logic [1:0] ADR_CTLB = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_DATA = 2'd3;

  // control A
  localparam int A_R9   = 7;
  localparam int A_T9   = 6;
  localparam int A_NINE = 4;
  localparam logic [REG_W-1:0] CTLA_WMASK = 8'h58;

  // control B
  localparam int B_TXE_IE = 7;
  localparam int B_TXC_IE = 6;
  localparam int B_RX_IE  = 5;
  localparam int B_TEN    = 4;
  localparam int B_IDL_IE = 3;
  localparam int B_BRK    = 2;
  localparam int B_REN    = 1;
  localparam logic [REG_W-1:0] CTLB_BOOT = 8'h12;

  // status
  localparam int S_TDRE = 7;
  localparam int S_TC   = 6;
  localparam int S_RDRF = 5;
  localparam int S_IDLE = 4;
  localparam int S_OVR  = 3;
  localparam int S_FE   = 1;
  localparam logic [REG_W-1:0] STAT_RXMASK = 8'h3E;

  function automatic int frame_bits(logic nine);
    return CHAR_W + 2 + (nine ? 1 : 0);
  endfunction

  // start bit in bit 0, then data LSB first, then ninth bit or stop, then stop
  function automatic logic [FRAME_W-1:0] frame_pack(logic [CHAR_W-1:0] d,
                                                    logic nine, logic ninth);
    return {1'b1, (nine ? ninth : 1'b1), d, 1'b0};
  endfunction

  function automatic logic irq_req(logic [REG_W-1:0] cb, logic [REG_W-1:0] st);
    return (cb[B_TXE_IE] & st[S_TDRE]) | (cb[B_TXC_IE] & st[S_TC]) |
           (cb[B_RX_IE] & (st[S_RDRF] | st[S_OVR])) | (cb[B_IDL_IE] & st[S_IDLE]);
  endfunction
endpackage

// File: rtl/sci_tx.sv
module sci_tx
  import sci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load,
  input  logic              nine,
  input  logic              ninth,
  input  logic [CHAR_W-1:0] data,
  input  logic              brk,
  output logic              txd,
  output logic              busy,
  output logic              frame_done
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q       <= '1;
      left_q     <= '0;
      line_q     <= 1'b1;
      busy       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (load) begin
        sh_q   <= frame_pack(data, nine, ninth);
        left_q <= CNT_W'(frame_bits(nine));
        busy   <= 1'b1;
      end else if (busy && bit_tick) begin
        if (left_q != '0) begin
          line_q <= sh_q[0];
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
        end else begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  assign txd = line_q & ~brk;
endmodule

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            enable,
  input  logic            nine,
  input  logic            rxd,
  output logic            char_done,
  output logic [CHAR_W:0] char_bits,
  output logic            stop_bad
);
  localparam int CNT_W = $clog2(CHAR_W + 2);

  logic [1:0]       sync_q;
  logic             rx_s;
  logic             active_q;
  logic [CNT_W-1:0] idx_q;
  logic [CHAR_W:0]  sh_q;
  logic [CNT_W-1:0] last_idx;

  assign rx_s     = sync_q[1];
  assign last_idx = nine ? CNT_W'(CHAR_W + 1) : CNT_W'(CHAR_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      active_q  <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      char_done <= 1'b0;
      char_bits <= '0;
      stop_bad  <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], rxd};
      char_done <= 1'b0;
      if (!enable) begin
        active_q <= 1'b0;
      end else if (bit_tick) begin
        if (!active_q) begin
          if (!rx_s) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            sh_q     <= '0;
          end
        end else if (idx_q != last_idx) begin
          sh_q[idx_q] <= rx_s;
          idx_q       <= idx_q + 1'b1;
        end else begin
          active_q  <= 1'b0;
          char_done <= 1'b1;
          char_bits <= sh_q;
          stop_bad  <= ~rx_s;
        end
      end
    end
  end
endmodule

// File: rtl/sci_unit.sv
module sci_unit
  import sci_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_mode,
  input  logic       bit_tick,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       rxd,
  output logic       txd
);
  logic [REG_W-1:0]  ctla_q, ctlb_q, cap_q, stat;
  logic [CHAR_W-1:0] hold_q;
  logic              hold_full_q, tdre_q, tc_q, rdrf_q, ovr_q, fe_q;
  logic              rdrf_c, ovr_c, fe_c;
  logic              wr_ctla, wr_ctlb, wr_data, rd_stat, rd_data;
  logic              tx_load, tx_busy, tx_done;
  logic              rx_done, rx_stop_bad;
  logic [CHAR_W:0]   rx_bits;

  assign wr_ctla = reg_wr && reg_addr == ADR_CTLA;
  assign wr_ctlb = reg_wr && reg_addr == ADR_CTLB;
  assign wr_data = reg_wr && reg_addr == ADR_DATA;
  assign rd_stat = reg_rd && reg_addr == ADR_STAT;
  assign rd_data = reg_rd && reg_addr == ADR_DATA;

  assign stat    = {tdre_q, tc_q, rdrf_q, 1'b0, ovr_q, 1'b0, fe_q, 1'b0};
  assign tx_load = ctlb_q[B_TEN] & hold_full_q & ~tx_busy;
  assign irq     = irq_req(ctlb_q, stat);

  always_comb begin
    rdrf_c = rdrf_q & ~(rd_data & cap_q[S_RDRF]);
    ovr_c  = ovr_q  & ~(rd_data & cap_q[S_OVR]);
    fe_c   = fe_q   & ~(rd_data & cap_q[S_FE]);
  end

  always_comb begin
    unique case (reg_addr)
      ADR_CTLA: reg_rdata = {rx_bits[CHAR_W], ctla_q[REG_W-2:0]};
      ADR_CTLB: reg_rdata = ctlb_q;
      ADR_STAT: reg_rdata = stat;
      default:  reg_rdata = rx_bits[CHAR_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctla_q      <= '0;
      ctlb_q      <= boot_mode ? CTLB_BOOT : '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      tdre_q      <= 1'b1;
      tc_q        <= 1'b1;
      rdrf_q      <= 1'b0;
      ovr_q       <= 1'b0;
      fe_q        <= 1'b0;
      cap_q       <= '0;
    end else begin
      if (wr_ctla) ctla_q <= reg_wdata & CTLA_WMASK;
      if (wr_ctlb) ctlb_q <= reg_wdata;
      if (wr_data && tdre_q) begin
        hold_q      <= reg_wdata;
        hold_full_q <= 1'b1;
        tdre_q      <= 1'b0;
      end
      if (tx_load) begin
        hold_full_q <= 1'b0;
        tc_q        <= 1'b0;
      end
      if (tx_done) begin
        tdre_q <= 1'b1;
        tc_q   <= 1'b1;
      end
      if (rd_stat) cap_q <= stat & STAT_RXMASK;
      if (rd_data) cap_q <= '0;
      if (rx_done) begin
        rdrf_q <= 1'b1;
        ovr_q  <= ovr_c | rdrf_c;
        fe_q   <= fe_c | rx_stop_bad;
        cap_q  <= '0;
      end else begin
        rdrf_q <= rdrf_c;
        ovr_q  <= ovr_c;
        fe_q   <= fe_c;
      end
    end
  end

  sci_tx u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(tx_load),
    .nine(ctla_q[A_NINE]), .ninth(ctla_q[A_T9]), .data(hold_q),
    .brk(ctlb_q[B_BRK]), .txd(txd), .busy(tx_busy), .frame_done(tx_done)
  );

  sci_rx u_rx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .enable(ctlb_q[B_REN]),
    .nine(ctla_q[A_NINE]), .rxd(rxd), .char_done(rx_done),
    .char_bits(rx_bits), .stop_bad(rx_stop_bad)
  );
endmodule

// File: rtl/sci_unit_chk.sv
module sci_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_load,
  input logic       tx_done,
  input logic       rx_done,
  input logic       wr_data,
  input logic       rd_data,
  input logic       tdre,
  input logic       tc,
  input logic       rdrf,
  input logic       ovr,
  input logic       cap_rdrf,
  input logic [7:0] stat,
  input logic [7:0] hold
);
  // R1
  a_r1_reset_status: assert property (@(posedge clk) !rst_n |=> stat == 8'hC0);
  // R4
  a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!tdre && !tc));
  a_r4_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (tdre && tc));
  // R5
  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tdre) |=> $stable(hold));
  // R6
  a_r6_char_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rdrf);
  // R8
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rdrf && !rd_data) |=> (ovr && rdrf));
  // R9
  a_r9_two_step_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && cap_rdrf && !rx_done) |=> !rdrf);
endmodule

bind sci_unit sci_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_done(tx_done),
  .rx_done(rx_done), .wr_data(wr_data), .rd_data(rd_data), .tdre(tdre_q),
  .tc(tc_q), .rdrf(rdrf_q), .ovr(ovr_q), .cap_rdrf(cap_q[5]), .stat(stat),
  .hold(hold_q)
);

// File: tb/test_sci_unit.sv
module test_sci_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_mode = 1'b0;
  logic       bit_tick;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       rxd = 1'b1;
  logic       txd;
  logic [2:0] tcnt = 3'd0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 3'd1;
  assign bit_tick = (tcnt == 3'd7);

  sci_unit i_sci_unit (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .bit_tick(bit_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rxd(rxd), .txd(txd)
  );

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    boot_mode = boot; rst_n = 1'b0; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; boot_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {3'b0, v}, {3'b0, exp});
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (bit_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine, input logic ninth,
                         input logic stop);
    logic [10:0] f;
    int n;
    n = nine ? 11 : 10;
    f = {1'b1, (nine ? ninth : stop), d, 1'b0};
    if (nine) f[10] = stop;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      rxd = f[i];
    end
    wait_tick();
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // returns with the sampling point in the middle of the last bit
  task automatic grab_tx(input int n, output logic [10:0] bits);
    int guard;
    bits = '1;
    guard = 0;
    while (txd !== 1'b0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bits[i] = txd;
      if (i < n - 1) repeat (8) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    rd_chk(2'd0, 8'h00, "R1 control A after reset");
    rd_chk(2'd1, 8'h00, "R1 control B after reset");
    rd_chk(2'd2, 8'hC0, "R1 status after reset");
    chk("R1 irq after reset", {10'b0, irq}, 11'd0);
    chk("R3 txd idles high", {10'b0, txd}, 11'd1);
  endtask

  task automatic t_boot();
    do_reset(1'b1);
    rd_chk(2'd1, 8'h12, "R2 boot preset control B");
    rd_chk(2'd2, 8'hC0, "R2 boot status");
  endtask

  task automatic t_tx8();
    logic [10:0] got;
    do_reset(1'b0);
    wr(2'd3, 8'hA5);
    rd_chk(2'd2, 8'h40, "R4 write clears TDRE only");
    wr(2'd3, 8'h3C);
    wr(2'd1, 8'h10);
    grab_tx(10, got);
    rd_chk(2'd2, 8'h00, "R4 load clears TC");
    chk("R3 R5 eight-bit frame", got, {1'b1, 1'b1, 8'hA5, 1'b0});
    repeat (20) @(negedge clk);
    rd_chk(2'd2, 8'hC0, "R4 frame end sets TDRE and TC");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) begin
        chk("R5 no second frame", {10'b0, txd}, 11'd1);
        break;
      end
    end
    rd_chk(2'd2, 8'hC0, "R5 status after ignored write");
  endtask

  task automatic t_tx9();
    logic [10:0] got;
    do_reset(1'b0);
    wr(2'd0, 8'h50);
    wr(2'd3, 8'h0F);
    wr(2'd1, 8'h10);
    grab_tx(11, got);
    chk("R3 nine-bit frame", got, {1'b1, 1'b1, 8'h0F, 1'b0});
    repeat (20) @(negedge clk);
  endtask

  task automatic t_break();
    do_reset(1'b0);
    wr(2'd1, 8'h14);
    chk("R14 break holds line low", {10'b0, txd}, 11'd0);
    wr(2'd1, 8'h10);
    chk("R14 line high after break", {10'b0, txd}, 11'd1);
  endtask

  task automatic t_rx();
    do_reset(1'b0);
    wr(2'd1, 8'h02);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    rd_chk(2'd3, 8'h5A, "R6 received data");
    rd_chk(2'd2, 8'hE0, "R9 data read alone leaves RDRF");
    rd_chk(2'd3, 8'h5A, "R9 data read after status");
    rd_chk(2'd2, 8'hC0, "R9 two-step clear");
    send_rx(8'h77, 1'b0, 1'b0, 1'b1);
    wr(2'd2, 8'h00);
    rd_chk(2'd2, 8'hE0, "R12 status write ignored");
    rd_chk(2'd3, 8'h77, "R12 data intact");
  endtask

  task automatic t_rx9();
    do_reset(1'b0);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h02);
    send_rx(8'h81, 1'b1, 1'b1, 1'b1);
    rd_chk(2'd0, 8'h90, "R6 ninth bit in control A");
    rd_chk(2'd3, 8'h81, "R6 nine-bit data");
  endtask

  task automatic t_rx_off();
    do_reset(1'b0);
    send_rx(8'h33, 1'b0, 1'b0, 1'b1);
    rd_chk(2'd2, 8'hC0, "R7 receiver disabled");
  endtask

  task automatic t_overrun();
    do_reset(1'b0);
    wr(2'd1, 8'h02);
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    rd_chk(2'd2, 8'hE8, "R8 overrun flag");
    rd_chk(2'd3, 8'h22, "R8 newer data kept");
    rd_chk(2'd2, 8'hC0, "R9 clears RDRF and OR");
  endtask

  task automatic t_cancel();
    do_reset(1'b0);
    wr(2'd1, 8'h02);
    send_rx(8'h44, 1'b0, 1'b0, 1'b1);
    rd_chk(2'd2, 8'hE0, "R10 first status");
    send_rx(8'h55, 1'b0, 1'b0, 1'b1);
    rd_chk(2'd3, 8'h55, "R10 data after new char");
    rd_chk(2'd2, 8'hE8, "R10 capture cancelled");
  endtask

  task automatic t_fe();
    do_reset(1'b0);
    wr(2'd1, 8'h02);
    send_rx(8'h66, 1'b0, 1'b0, 1'b0);
    rd_chk(2'd2, 8'hE2, "R11 framing flag");
    rd_chk(2'd3, 8'h66, "R11 data");
    rd_chk(2'd2, 8'hC0, "R11 framing flag cleared");
  endtask

  task automatic t_irq();
    do_reset(1'b0);
    wr(2'd1, 8'h80);
    chk("R13 TDRE term", {10'b0, irq}, 11'd1);
    wr(2'd1, 8'h40);
    chk("R13 TC term", {10'b0, irq}, 11'd1);
    wr(2'd1, 8'h22);
    chk("R13 RX term idle", {10'b0, irq}, 11'd0);
    send_rx(8'h01, 1'b0, 1'b0, 1'b1);
    chk("R13 RX term full", {10'b0, irq}, 11'd1);
    rd_chk(2'd2, 8'hE0, "R13 status");
    rd_chk(2'd3, 8'h01, "R13 data");
    chk("R13 RX term cleared", {10'b0, irq}, 11'd0);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_tx8();
    t_tx9();
    t_break();
    t_rx();
    t_rx9();
    t_rx_off();
    t_overrun();
    t_cancel();
    t_fe();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule